// File: doc/BRIEF.md
# Audio Codec Indexed Register File

This block is the host-facing register set of an audio codec. The host sees four byte-wide ports, selected by a 2-bit address. An index register chooses one of 32 primary slots. A data window reads and writes the chosen slot. A status byte is read-only. The remaining port reads as zero.

When the extended variant is strapped on and a mode field in primary register 12 is set, primary register 23 becomes a gateway to a second bank of 32 extended registers. Access through it takes two phases:

- **Pointer phase.** While the gateway's enable bit is clear, a write to register 23 loads a 5-bit extended pointer. The pointer is assembled from non-adjacent data bits.
- **Data phase.** Once the enable bit is set, writes to register 23 land in the extended register that the pointer names.

Extended register 4 carries remap controls. These redirect the auxiliary volume pair, primary registers 18 and 19, onto extended storage for reads and for writes.

Top module: `codec_regs`

## Requirements
- R1: Reading port 0 returns the 5-bit index in bits 4:0 with bits 7:5 zero. Port 3 always reads 0x00. Writes to ports 2 and 3 change no register.
- R2: After a synchronous reset, the index is 0, every primary and extended register is 0, and status is 0xCC.
- R3: With the gateway and remap paths inactive, a port-1 write to index i (i below 28) stores the byte, and a port-1 read at index i returns it.
- R4: Primary indices 28 to 31 are unimplemented. They read as 0x00 and ignore writes.
- R5: The gateway is active only when the extended-variant input is 1 and bits 6:5 of primary register 12 are both 1. Otherwise register 23 is an ordinary register.
- R6: With the gateway active and bit 3 of register 23 clear, a write to register 23 has two effects. It stores the byte in register 23. It also loads the extended pointer as {data[2], data[7:4]}, so data bit 2 is the pointer MSB.
- R7: With the gateway active and bit 3 of register 23 set, a write to register 23 stores the byte in the extended register at the pointer and leaves register 23 unchanged. Pointers 0 and 1 also copy the byte into primary registers 18 and 19.
- R8: With the extended variant on, the read value at index 18 or 19 depends on extended register 4. If its bit 2 is set, the read returns extended register (index−12), that is 6 or 7. Otherwise, if its bit 3 is set, the read returns extended register (index−2), that is 16 or 17.
- R9: With the extended variant on, a write to index 18 or 19 is handled according to extended register 4. If bits 4 and 2 are both set, the byte goes to extended register (index−12) and primary 18 or 19 keeps its value. Otherwise the write is ordinary.
- R10: Status reads 0xCC at all times after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| extVariant | input | 1 | Strap enabling the extended bank and volume remap |
| wrEn | input | 1 | Write strobe, one byte per cycle |
| addr | input | 2 | Port select: 0 index, 1 data window, 2 status, 3 unused |
| wrData | input | 8 | Write byte |
| rdData | output | 8 | Combinational read of the addressed port |

## Verification
The extended bank has no direct read path. Its contents can only be seen through the remapped reads of indices 18 and 19, which expose extended registers 6, 7, 16 and 17, and through the write-through into primary registers 18 and 19.

Once the gateway enable bit is set, it can only be cleared by first closing the gateway through register 12 and then writing register 23 as an ordinary register. The stimulus therefore biases the index toward 12, 18, 19 and 23, and sets bits 6:5 and bit 3 in the written bytes often enough to open and close the gateway many times.

Directed sequences walk through specific checks:
- the split pointer bit, by loading pointer 16 with data bit 2;
- the write-through at pointers 0 and 1;
- the priority between remap bits 2 and 3;
- that primary register 18 keeps its value under a remapped write.

// File: rtl/codec_regs_pkg.sv
package codec_regs_pkg;
  localparam int RegW = 8;
  localparam int IdxW = 5;

  typedef struct packed {
    logic            idxWe;
    logic            baseWe;
    logic [IdxW-1:0] baseSel;
    logic            extWe;
    logic [IdxW-1:0] extSel;
    logic            ptrWe;
  } strobe_t;

  typedef enum logic [2:0] {
    SRC_ZERO,
    SRC_IDX,
    SRC_STAT,
    SRC_BASE,
    SRC_EXT
  } rdsrc_t;

  typedef struct packed {
    logic [IdxW-1:0] idx;
    logic [IdxW-1:0] ptr;
    logic [RegW-1:0] modeReg;
    logic [RegW-1:0] gateReg;
    logic [RegW-1:0] remapReg;
  } cfg_t;
endpackage

// File: rtl/codec_regs_ctrl.sv
module codec_regs_ctrl
  import codec_regs_pkg::*;
#(
  parameter int NUM_BASE = 28
) (
  input  logic            extVariant,
  input  logic            wrEn,
  input  logic [1:0]      addr,
  input  cfg_t            cfg,
  output strobe_t         strb,
  output rdsrc_t          rdSrc,
  output logic [IdxW-1:0] rdSel
);
  localparam logic [IdxW-1:0] GateIdx = 5'd23;
  localparam logic [IdxW-1:0] VolL    = 5'd18;
  localparam logic [IdxW-1:0] VolR    = 5'd19;
  localparam logic [IdxW-1:0] Limit   = IdxW'(NUM_BASE);

  logic gateOpen, dataPhase, isVol, remapWr, remapRdA, remapRdB, implemented;

  always_comb begin
    gateOpen    = extVariant && (cfg.modeReg[6:5] == 2'b11);
    dataPhase   = cfg.gateReg[3];
    isVol       = (cfg.idx == VolL) || (cfg.idx == VolR);
    remapWr     = extVariant && cfg.remapReg[4] && cfg.remapReg[2];
    remapRdA    = extVariant && cfg.remapReg[2];
    remapRdB    = extVariant && cfg.remapReg[3];
    implemented = cfg.idx < Limit;
  end

  always_comb begin
    strb = '0;
    if (wrEn) begin
      unique case (addr)
        2'd0: strb.idxWe = 1'b1;
        2'd1: begin
          if (cfg.idx == GateIdx && gateOpen) begin
            if (!dataPhase) begin
              strb.baseWe  = 1'b1;
              strb.baseSel = GateIdx;
              strb.ptrWe   = 1'b1;
            end else begin
              strb.extWe  = 1'b1;
              strb.extSel = cfg.ptr;
              if (cfg.ptr < 5'd2) begin
                strb.baseWe  = 1'b1;
                strb.baseSel = VolL + cfg.ptr;
              end
            end
          end else if (isVol && remapWr) begin
            strb.extWe  = 1'b1;
            strb.extSel = cfg.idx - 5'd12;
          end else if (implemented) begin
            strb.baseWe  = 1'b1;
            strb.baseSel = cfg.idx;
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rdSrc = SRC_ZERO;
    rdSel = '0;
    unique case (addr)
      2'd0: rdSrc = SRC_IDX;
      2'd1: begin
        if (isVol && remapRdA) begin
          rdSrc = SRC_EXT;
          rdSel = cfg.idx - 5'd12;
        end else if (isVol && remapRdB) begin
          rdSrc = SRC_EXT;
          rdSel = cfg.idx - 5'd2;
        end else if (implemented) begin
          rdSrc = SRC_BASE;
          rdSel = cfg.idx;
        end
      end
      2'd2: rdSrc = SRC_STAT;
      default: rdSrc = SRC_ZERO;
    endcase
  end
endmodule

// File: rtl/codec_regs_dp.sv
module codec_regs_dp
  import codec_regs_pkg::*;
#(
  parameter int              NUM_BASE = 28,
  parameter logic [RegW-1:0] STAT_RST = 8'hCC
) (
  input  logic            clk,
  input  logic            rst,
  input  strobe_t         strb,
  input  rdsrc_t          rdSrc,
  input  logic [IdxW-1:0] rdSel,
  input  logic [RegW-1:0] wrData,
  output logic [RegW-1:0] rdData,
  output cfg_t            cfg
);
  localparam int NumExt = 1 << IdxW;

  logic [RegW-1:0] baseQ [NUM_BASE];
  logic [RegW-1:0] extQ  [NumExt];
  logic [IdxW-1:0] idxQ, ptrQ;
  logic [RegW-1:0] statQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      idxQ  <= '0;
      ptrQ  <= '0;
      statQ <= STAT_RST;
    end else begin
      if (strb.idxWe) idxQ <= wrData[IdxW-1:0];
      if (strb.ptrWe) ptrQ <= {wrData[2], wrData[7:4]};
    end
  end

  for (genvar g = 0; g < NUM_BASE; g++) begin : gBase
    always_ff @(posedge clk) begin
      if (rst) baseQ[g] <= '0;
      else if (strb.baseWe && strb.baseSel == IdxW'(g)) baseQ[g] <= wrData;
    end
  end

  for (genvar g = 0; g < NumExt; g++) begin : gExt
    always_ff @(posedge clk) begin
      if (rst) extQ[g] <= '0;
      else if (strb.extWe && strb.extSel == IdxW'(g)) extQ[g] <= wrData;
    end
  end

  always_comb begin
    cfg.idx      = idxQ;
    cfg.ptr      = ptrQ;
    cfg.modeReg  = baseQ[12];
    cfg.gateReg  = baseQ[23];
    cfg.remapReg = extQ[4];
  end

  always_comb begin
    unique case (rdSrc)
      SRC_IDX:  rdData = {{(RegW-IdxW){1'b0}}, idxQ};
      SRC_STAT: rdData = statQ;
      SRC_BASE: rdData = baseQ[rdSel];
      SRC_EXT:  rdData = extQ[rdSel];
      default:  rdData = '0;
    endcase
  end
endmodule

// File: rtl/codec_regs.sv
module codec_regs
  import codec_regs_pkg::*;
#(
  parameter int              NUM_BASE = 28,
  parameter logic [RegW-1:0] STAT_RST = 8'hCC
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       extVariant,
  input  logic       wrEn,
  input  logic [1:0] addr,
  input  logic [7:0] wrData,
  output logic [7:0] rdData
);
  strobe_t         strb;
  rdsrc_t          rdSrc;
  logic [IdxW-1:0] rdSel;
  cfg_t            cfg;

  codec_regs_ctrl #(.NUM_BASE(NUM_BASE)) u_ctrl (
    .extVariant(extVariant), .wrEn(wrEn), .addr(addr), .cfg(cfg),
    .strb(strb), .rdSrc(rdSrc), .rdSel(rdSel)
  );

  codec_regs_dp #(.NUM_BASE(NUM_BASE), .STAT_RST(STAT_RST)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .rdSrc(rdSrc), .rdSel(rdSel),
    .wrData(wrData), .rdData(rdData), .cfg(cfg)
  );
endmodule

// File: rtl/codec_regs_sva.sv
module codec_regs_sva
  import codec_regs_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       extVariant,
  input logic       wrEn,
  input logic [1:0] addr,
  input logic [7:0] wrData,
  input logic [7:0] rdData,
  input cfg_t       cfg
);
  logic gateOpen;
  assign gateOpen = extVariant && (cfg.modeReg[6:5] == 2'b11);

  a_r1_port3_zero: assert property (@(posedge clk) disable iff (rst)
    (addr == 2'd3) |-> (rdData == 8'h00));

  a_r1_idx_upper: assert property (@(posedge clk) disable iff (rst)
    (addr == 2'd0) |-> (rdData[7:5] == 3'b000));

  a_r10_status: assert property (@(posedge clk) disable iff (rst)
    (addr == 2'd2) |-> (rdData == 8'hCC));

  a_r2_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cfg.idx == 5'd0 && cfg.ptr == 5'd0 && cfg.remapReg == 8'h00));

  a_r4_high_zero: assert property (@(posedge clk) disable iff (rst)
    (addr == 2'd1 && cfg.idx >= 5'd28) |-> (rdData == 8'h00));

  a_r5_gate_closed: assert property (@(posedge clk) disable iff (rst)
    (wrEn && addr == 2'd1 && cfg.idx == 5'd23 && !gateOpen) |=> (cfg.gateReg == $past(wrData)));

  a_r6_ptr_load: assert property (@(posedge clk) disable iff (rst)
    (wrEn && addr == 2'd1 && cfg.idx == 5'd23 && gateOpen && !cfg.gateReg[3])
      |=> (cfg.ptr == {$past(wrData[2]), $past(wrData[7:4])}));

  a_r7_gate_hold: assert property (@(posedge clk) disable iff (rst)
    (wrEn && addr == 2'd1 && cfg.idx == 5'd23 && gateOpen && cfg.gateReg[3])
      |=> $stable(cfg.gateReg));
endmodule

bind codec_regs codec_regs_sva u_sva (
  .clk(clk), .rst(rst), .extVariant(extVariant), .wrEn(wrEn), .addr(addr),
  .wrData(wrData), .rdData(rdData), .cfg(cfg)
);

// File: tb/sim_codec_regs.sv
module sim_codec_regs;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       extVariant = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;

  int  total = 0;
  int  bad = 0;
  bit  done = 1'b0;

  logic [7:0] mBase [32];
  logic [7:0] mExt  [32];
  logic [4:0] mIdx, mPtr;

  always #5 clk = ~clk;

  codec_regs u0 (.clk(clk), .rst(rst), .extVariant(extVariant), .wrEn(wrEn),
                 .addr(addr), .wrData(wrData), .rdData(rdData));

  function automatic logic [7:0] expRead(input logic [1:0] a);
    logic isVol;
    isVol = (mIdx == 5'd18) || (mIdx == 5'd19);
    case (a)
      2'd0: return {3'b000, mIdx};
      2'd2: return 8'hCC;
      2'd3: return 8'h00;
      default: begin
        if (isVol && extVariant && mExt[4][2]) return mExt[mIdx - 5'd12];
        if (isVol && extVariant && mExt[4][3]) return mExt[mIdx - 5'd2];
        if (mIdx >= 5'd28) return 8'h00;
        return mBase[mIdx];
      end
    endcase
  endfunction

  task automatic modelWrite(input logic [1:0] a, input logic [7:0] d);
    logic gate;
    gate = extVariant && (mBase[12][6:5] == 2'b11);
    if (a == 2'd0) mIdx = d[4:0];
    else if (a == 2'd1) begin
      if (mIdx == 5'd23 && gate) begin
        if (!mBase[23][3]) begin
          mBase[23] = d;
          mPtr = {d[2], d[7:4]};
        end else begin
          mExt[mPtr] = d;
          if (mPtr < 5'd2) mBase[5'd18 + mPtr] = d;
        end
      end else if ((mIdx == 5'd18 || mIdx == 5'd19) && extVariant && mExt[4][4] && mExt[4][2])
        mExt[mIdx - 5'd12] = d;
      else if (mIdx < 5'd28) mBase[mIdx] = d;
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    modelWrite(a, d);
  endtask

  task automatic chk(input logic [1:0] a, input string tag);
    logic [7:0] e;
    @(negedge clk);
    addr = a; wrEn = 1'b0;
    #1;
    e = expRead(a);
    total++;
    if (rdData !== e) begin
      bad++;
      $display("FAIL %s port=%0d idx=%0d actual=%02h expected=%02h", tag, a, mIdx, rdData, e);
    end
  endtask

  task automatic rdIdx(input logic [4:0] i, input string tag);
    wr(2'd0, {3'b000, i});
    chk(2'd1, tag);
  endtask

  function automatic logic [4:0] pickIdx();
    case ($urandom % 12)
      0, 1: return 5'd23;
      2, 3: return 5'd12;
      4:    return 5'd18;
      5:    return 5'd19;
      6:    return 5'd30;
      default: return 5'($urandom);
    endcase
  endfunction

  function automatic logic [7:0] pickData();
    logic [7:0] d;
    d = 8'($urandom);
    if ($urandom % 2 == 0) d = d | 8'h60;
    if ($urandom % 3 == 0) d = d | 8'h08;
    if ($urandom % 3 == 0) d = d | 8'h14;
    return d;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 32; i++) begin mBase[i] = 8'h00; mExt[i] = 8'h00; end
    mIdx = '0; mPtr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R2: reset state
    chk(2'd0, "R2 index reset");
    chk(2'd2, "R2 status reset");
    chk(2'd1, "R2 reg0 reset");
    rdIdx(5'd18, "R2 reg18 reset");
    // R1: port 3 and writes to ports 2/3
    chk(2'd3, "R1 port3 zero");
    wr(2'd2, 8'h00); wr(2'd3, 8'hFF);
    chk(2'd2, "R1 R10 status after port2 write");
    rdIdx(5'd18, "R1 data after port3 write");
    wr(2'd0, 8'hFF);
    chk(2'd0, "R1 index upper bits zero");
    // R3: ordinary write
    wr(2'd0, 8'd5); wr(2'd1, 8'hA5); chk(2'd1, "R3 reg5 write");
    wr(2'd0, 8'd27); wr(2'd1, 8'h3C); chk(2'd1, "R3 reg27 write");
    // R4: unimplemented
    wr(2'd0, 8'd30); wr(2'd1, 8'h77); chk(2'd1, "R4 reg30 reads zero");
    // R5: gate closed without variant
    extVariant = 1'b0;
    wr(2'd0, 8'd12); wr(2'd1, 8'h60);
    wr(2'd0, 8'd23); wr(2'd1, 8'h48); wr(2'd1, 8'h91);
    chk(2'd1, "R5 reg23 ordinary without variant");
    // R6/R7: open gate, pointer 4, set remap control
    extVariant = 1'b1;
    wr(2'd0, 8'd23); wr(2'd1, 8'h00);
    wr(2'd1, 8'h48);
    chk(2'd1, "R6 reg23 stores pointer byte");
    wr(2'd1, 8'h14);
    chk(2'd1, "R7 reg23 unchanged in data phase");
    // R9/R8: remapped write of 18, base untouched
    wr(2'd0, 8'd18); wr(2'd1, 8'h3A);
    chk(2'd1, "R8 R9 read 18 from ext6");
    wr(2'd0, 8'd23); wr(2'd1, 8'h08);
    rdIdx(5'd18, "R8 read 18 from ext16");
    wr(2'd0, 8'd23); wr(2'd1, 8'h00);
    rdIdx(5'd18, "R9 base18 kept");
    // R6 split pointer bit: pointer 16 via data bit 2
    wr(2'd0, 8'd12); wr(2'd1, 8'h00);
    wr(2'd0, 8'd23); wr(2'd1, 8'h00);
    wr(2'd0, 8'd12); wr(2'd1, 8'h60);
    wr(2'd0, 8'd23); wr(2'd1, 8'h0C); wr(2'd1, 8'h21);
    wr(2'd0, 8'd12); wr(2'd1, 8'h00);
    wr(2'd0, 8'd23); wr(2'd1, 8'h00);
    wr(2'd0, 8'd12); wr(2'd1, 8'h60);
    wr(2'd0, 8'd23); wr(2'd1, 8'h48); wr(2'd1, 8'h08);
    rdIdx(5'd19, "R6 pointer MSB from bit2, ext17 zero");
    rdIdx(5'd18, "R6 pointer MSB from bit2, ext16");
    // R7 write-through at pointer 1
    wr(2'd0, 8'd23); wr(2'd1, 8'h00);
    wr(2'd0, 8'd12); wr(2'd1, 8'h00);
    wr(2'd0, 8'd23); wr(2'd1, 8'h00);
    wr(2'd0, 8'd12); wr(2'd1, 8'h60);
    wr(2'd0, 8'd23); wr(2'd1, 8'h18); wr(2'd1, 8'h5E);
    rdIdx(5'd19, "R7 write-through to reg19");

    // mixed random phase
    for (int n = 0; n < 3000; n++) begin
      case ($urandom % 6)
        0: wr(2'd0, {3'b000, pickIdx()});
        1, 2: wr(2'd1, pickData());
        3: chk(2'($urandom), "R1 R3 R10 random port read");
        4: chk(2'd1, "R3 R8 random data read");
        default: begin
          if ($urandom % 6 == 0) extVariant = ~extVariant;
          wr(2'($urandom % 4), 8'($urandom));
        end
      endcase
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule